// File: doc/BRIEF.md
# Per-Channel Trigger Pattern Matcher

This block watches a bus of probe channels sampled on the rising edge of the acquisition clock. It raises a one-cycle trigger event when every channel with an active condition meets that condition in the same sample. Each channel holds its own 3-bit condition. The condition can be a level test (high or low), an edge test (rising, falling or either), or don't care. Edge tests compare the current sample with the one before it.

An external trigger-input pin is sampled alongside the channels. It is qualified with the same set of conditions and ANDed into the match. A registered trigger-output pin mirrors the event, and its polarity can be chosen. All conditions and the polarity are loaded through a small write port and may be changed while the block runs. A restart input discards the sample history so that edge tests start afresh.

Top module: `pattern_trigger`

## Requirements
- R1: Each channel condition code means: 0 don't care, 1 high, 2 low, 3 rising edge (previous 0, current 1), 4 falling edge (previous 1, current 0), 5 either edge (previous differs from current). Codes 6 and 7 act as don't care.
- R2: After reset every channel condition and the trigger-input condition are don't care, the polarity is active high, and both trigEvent and trigOut are 0.
- R3: Inputs are captured on a rising clock edge. If every channel and the trigger input satisfy their conditions for that capture, trigEvent is 1 for exactly the clock cycle that follows the next rising edge.
- R4: Edge conditions are never satisfied without a valid previous sample. This holds for the first capture after reset and for a capture made on an edge where restartIn is 1. No event is produced from the reset contents of the sample registers.
- R5: Level conditions compare only the current sample and are met on the first capture after reset or restart.
- R6: The trigger-input pin uses the codes of R1. Its condition is ANDed with the channel match, and when it is don't care it is always met.
- R7: When every channel condition and the trigger-input condition are don't care, no event fires, whatever the inputs do.
- R8: trigOut equals trigEvent XOR the polarity bit in use at the edge that set trigEvent. A write with cfgWrData bit 0 = 1 to address NUM_CH+1 selects active low, so the idle level becomes 1.
- R9: A write with cfgWrEn sets the code at cfgAddr. Addresses 0..NUM_CH-1 select channels, and address NUM_CH selects the trigger input. The new code applies to the sample captured on the same edge. Writes to addresses above NUM_CH+1 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Acquisition clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| restartIn | input | 1 | Discards sample history at this edge |
| probeIn | input | NUM_CH | Probe channels |
| extTrigIn | input | 1 | External trigger input pin |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | $clog2(NUM_CH+2) | Configuration address |
| cfgWrData | input | 3 | Condition code, or polarity in bit 0 |
| trigEvent | output | 1 | One-cycle trigger event, active high |
| trigOut | output | 1 | Trigger output pin with programmed polarity |

## Verification
A configuration write and the capture it affects can land on the same edge. A restart can also coincide with an edge transition that an edge condition waits for. Directed sequences provoke both cases: one writes a channel code on the very edge that captures a matching sample, and another asserts restart on the edge where a rising transition occurs. Random cycles then mix writes, restarts and probe changes on the same edges. Each outcome is judged against a bench model that applies the new code to that capture and suppresses the masked edge.

// File: rtl/trig_pkg.sv
package trig_pkg;

  typedef enum logic [2:0] {
    COND_ANY    = 3'd0,
    COND_HIGH   = 3'd1,
    COND_LOW    = 3'd2,
    COND_RISE   = 3'd3,
    COND_FALL   = 3'd4,
    COND_EITHER = 3'd5
  } trig_cond_e;

  // strobes from control to datapath
  typedef struct packed {
    logic levelOk;  // current sample register holds a real capture
    logic edgeOk;   // previous sample register holds a real capture too
    logic polLow;   // trigger output active low
  } ctrl_strobe_t;

  function automatic logic condActive(input logic [2:0] code);
    return (code != 3'd0) && (code <= 3'd5);
  endfunction

  function automatic logic condMet(input logic [2:0] code, input logic cur,
                                   input logic prev, input logic levelOk,
                                   input logic edgeOk);
    logic met;
    case (code)
      COND_HIGH:   met = levelOk & cur;
      COND_LOW:    met = levelOk & ~cur;
      COND_RISE:   met = edgeOk & cur & ~prev;
      COND_FALL:   met = edgeOk & ~cur & prev;
      COND_EITHER: met = edgeOk & (cur ^ prev);
      default:     met = 1'b1;
    endcase
    return met;
  endfunction

endpackage

// File: rtl/trig_ctrl.sv
module trig_ctrl
  import trig_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int ADDR_W = $clog2(NUM_CH + 2)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  restartIn,
  input  logic                  cfgWrEn,
  input  logic [ADDR_W-1:0]     cfgAddr,
  input  logic [2:0]            cfgWrData,
  output logic [NUM_CH*3-1:0]   chCodes,
  output logic [2:0]            extCode,
  output ctrl_strobe_t          strobe
);

  localparam logic [ADDR_W-1:0] EXT_ADDR = ADDR_W'(NUM_CH);
  localparam logic [ADDR_W-1:0] POL_ADDR = ADDR_W'(NUM_CH + 1);

  logic [1:0] fillQ;
  logic       polQ;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_code
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chCodes[ch*3 +: 3] <= 3'd0;
      else if (cfgWrEn && cfgAddr == ADDR_W'(ch)) chCodes[ch*3 +: 3] <= cfgWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extCode <= 3'd0;
      polQ    <= 1'b0;
    end else if (cfgWrEn) begin
      if (cfgAddr == EXT_ADDR) extCode <= cfgWrData;
      if (cfgAddr == POL_ADDR) polQ    <= cfgWrData[0];
    end
  end

  // count of real captures held in the two sample registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               fillQ <= 2'd0;
    else if (restartIn)      fillQ <= 2'd1;
    else if (fillQ != 2'd2)  fillQ <= fillQ + 2'd1;
  end

  always_comb begin
    strobe.levelOk = (fillQ != 2'd0);
    strobe.edgeOk  = (fillQ == 2'd2);
    strobe.polLow  = polQ;
  end

endmodule

// File: rtl/trig_datapath.sv
module trig_datapath
  import trig_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_CH-1:0]   probeIn,
  input  logic                extTrigIn,
  input  logic [NUM_CH*3-1:0] chCodes,
  input  logic [2:0]          extCode,
  input  ctrl_strobe_t        strobe,
  output logic                trigEvent,
  output logic                trigOut
);

  logic [NUM_CH-1:0] curQ, prevQ, chMet, chActive;
  logic              extCurQ, extPrevQ, extMet, hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curQ     <= '0;
      prevQ    <= '0;
      extCurQ  <= 1'b0;
      extPrevQ <= 1'b0;
    end else begin
      curQ     <= probeIn;
      prevQ    <= curQ;
      extCurQ  <= extTrigIn;
      extPrevQ <= extCurQ;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_eval
    assign chMet[ch]    = condMet(chCodes[ch*3 +: 3], curQ[ch], prevQ[ch],
                                  strobe.levelOk, strobe.edgeOk);
    assign chActive[ch] = condActive(chCodes[ch*3 +: 3]);
  end

  assign extMet = condMet(extCode, extCurQ, extPrevQ, strobe.levelOk, strobe.edgeOk);
  assign hit    = (&chMet) & extMet & ((|chActive) | condActive(extCode));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigEvent <= 1'b0;
      trigOut   <= 1'b0;
    end else begin
      trigEvent <= hit;
      trigOut   <= hit ^ strobe.polLow;
    end
  end

endmodule

// File: rtl/pattern_trigger.sv
module pattern_trigger
  import trig_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int ADDR_W = $clog2(NUM_CH + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              restartIn,
  input  logic [NUM_CH-1:0] probeIn,
  input  logic              extTrigIn,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [2:0]        cfgWrData,
  output logic              trigEvent,
  output logic              trigOut
);

  logic [NUM_CH*3-1:0] chCodes;
  logic [2:0]          extCode;
  ctrl_strobe_t        ctrlStb;

  trig_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rstN(rstN), .restartIn(restartIn), .cfgWrEn(cfgWrEn),
    .cfgAddr(cfgAddr), .cfgWrData(cfgWrData), .chCodes(chCodes),
    .extCode(extCode), .strobe(ctrlStb)
  );

  trig_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .probeIn(probeIn), .extTrigIn(extTrigIn),
    .chCodes(chCodes), .extCode(extCode), .strobe(ctrlStb),
    .trigEvent(trigEvent), .trigOut(trigOut)
  );

endmodule

// File: rtl/trig_match_chk.sv
module trig_match_chk #(
  parameter int NUM_CH = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                restartIn,
  input logic                trigEvent,
  input logic                trigOut,
  input logic                levelOk,
  input logic                edgeOk,
  input logic                polLow,
  input logic [NUM_CH*3-1:0] chCodes,
  input logic [2:0]          extCode
);

  logic allDc;
  always_comb begin
    allDc = (extCode == 3'd0) || (extCode > 3'd5);
    for (int ch = 0; ch < NUM_CH; ch++)
      if (chCodes[ch*3 +: 3] != 3'd0 && chCodes[ch*3 +: 3] <= 3'd5) allDc = 1'b0;
  end

  assert_no_hist_fire_R4: assert property (@(posedge clk) disable iff (!rstN)
    !levelOk |=> !trigEvent);

  assert_restart_clears_edge_R4: assert property (@(posedge clk) disable iff (!rstN)
    restartIn |=> (levelOk && !edgeOk));

  assert_all_dc_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    allDc |=> !trigEvent);

  assert_out_polarity_R8: assert property (@(posedge clk) disable iff (!rstN)
    trigOut == (trigEvent ^ $past(polLow)));

endmodule

bind pattern_trigger trig_match_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .restartIn(restartIn), .trigEvent(trigEvent),
  .trigOut(trigOut), .levelOk(ctrlStb.levelOk), .edgeOk(ctrlStb.edgeOk),
  .polLow(ctrlStb.polLow), .chCodes(chCodes), .extCode(extCode)
);

// File: tb/tb_pattern_trigger.sv
module tb_pattern_trigger;

  localparam int NUM_CH = 8;
  localparam int ADDR_W = $clog2(NUM_CH + 2);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              restartIn = 1'b0;
  logic [NUM_CH-1:0] probeIn = '0;
  logic              extTrigIn = 1'b0;
  logic              cfgWrEn = 1'b0;
  logic [ADDR_W-1:0] cfgAddr = '0;
  logic [2:0]        cfgWrData = '0;
  logic              trigEvent, trigOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  pattern_trigger #(.NUM_CH(NUM_CH)) dut (.*);

  // bench model
  logic [2:0]        mCode [NUM_CH];
  logic [2:0]        mExt;
  logic              mPol;
  logic [NUM_CH-1:0] mCur, mPrev;
  logic              mExtCur, mExtPrev;
  int                mFill;
  logic              expEvent, expOut;

  function automatic logic okCond(input logic [2:0] c, input logic cur,
                                  input logic prev, input int fill);
    case (c)
      3'd1: return fill >= 1 && cur;
      3'd2: return fill >= 1 && !cur;
      3'd3: return fill == 2 && cur && !prev;
      3'd4: return fill == 2 && !cur && prev;
      3'd5: return fill == 2 && (cur != prev);
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic isActive(input logic [2:0] c);
    return c >= 3'd1 && c <= 3'd5;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < NUM_CH; i++) mCode[i] = 3'd0;
    mExt = 3'd0; mPol = 1'b0; mCur = '0; mPrev = '0;
    mExtCur = 1'b0; mExtPrev = 1'b0; mFill = 0;
    expEvent = 1'b0; expOut = 1'b0;
  endtask

  task automatic modelEdge();
    logic all, any;
    all = okCond(mExt, mExtCur, mExtPrev, mFill);
    any = isActive(mExt);
    for (int i = 0; i < NUM_CH; i++) begin
      all = all & okCond(mCode[i], mCur[i], mPrev[i], mFill);
      any = any | isActive(mCode[i]);
    end
    expEvent = all & any;
    expOut   = expEvent ^ mPol;
    mPrev = mCur; mCur = probeIn; mExtPrev = mExtCur; mExtCur = extTrigIn;
    if (restartIn) mFill = 1; else if (mFill < 2) mFill = mFill + 1;
    if (cfgWrEn) begin
      if (int'(cfgAddr) < NUM_CH) mCode[cfgAddr] = cfgWrData;
      else if (int'(cfgAddr) == NUM_CH) mExt = cfgWrData;
      else if (int'(cfgAddr) == NUM_CH + 1) mPol = cfgWrData[0];
    end
  endtask

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0b expected %0b", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, model the edge, check at next negedge
  task automatic step(input string tag, input logic [NUM_CH-1:0] p, input logic e,
                      input logic rs, input logic we, input int a, input logic [2:0] d);
    probeIn = p; extTrigIn = e; restartIn = rs; cfgWrEn = we;
    cfgAddr = ADDR_W'(a); cfgWrData = d;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    cfgWrEn = 1'b0; restartIn = 1'b0;
    check(tag, trigEvent, expEvent, "trigEvent");
    check(tag, trigOut, expOut, "trigOut");
  endtask

  task automatic wr(input string tag, input int a, input logic [2:0] d);
    step(tag, probeIn, extTrigIn, 1'b0, 1'b1, a, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    modelReset();
    repeat (3) @(negedge clk);
    check("R2", trigEvent, 1'b0, "reset trigEvent");
    check("R2", trigOut, 1'b0, "reset trigOut");
    rstN = 1'b1;

    // R2/R7: nothing armed, probes toggle freely
    for (int i = 0; i < 6; i++) step("R7", NUM_CH'($urandom), i[0], 1'b0, 1'b0, 0, 3'd0);
    check("R7", trigEvent, 1'b0, "all dont care");

    // R9/R5: write ch0=high on the same edge that captures a 1
    step("R9", 8'h01, 1'b0, 1'b0, 1'b1, 0, 3'd1);
    step("R5", 8'h00, 1'b0, 1'b0, 1'b0, 0, 3'd0);
    check("R5", trigEvent, 1'b1, "high matched");
    step("R3", 8'h00, 1'b0, 1'b0, 1'b0, 0, 3'd0);
    check("R3", trigEvent, 1'b0, "pulse ends");

    // R4: ch1 rising with restart on the rising edge
    wr("R1", 0, 3'd0);
    wr("R1", 1, 3'd3);
    step("R4", 8'h00, 1'b0, 1'b0, 1'b0, 0, 3'd0);
    step("R4", 8'h02, 1'b0, 1'b1, 1'b0, 0, 3'd0);
    step("R4", 8'h00, 1'b0, 1'b0, 1'b0, 0, 3'd0);
    check("R4", trigEvent, 1'b0, "edge after restart suppressed");
    step("R1", 8'h02, 1'b0, 1'b0, 1'b0, 0, 3'd0);
    step("R1", 8'h02, 1'b0, 1'b0, 1'b0, 0, 3'd0);
    check("R1", trigEvent, 1'b1, "rising matched");

    // R6: ext low qualifier with ch1 either edge
    wr("R6", 1, 3'd5);
    wr("R6", NUM_CH, 3'd2);
    step("R6", 8'h00, 1'b1, 1'b0, 1'b0, 0, 3'd0);
    step("R6", 8'h02, 1'b1, 1'b0, 1'b0, 0, 3'd0);
    check("R6", trigEvent, 1'b0, "ext high blocks");
    step("R6", 8'h00, 1'b0, 1'b0, 1'b0, 0, 3'd0);
    step("R6", 8'h00, 1'b0, 1'b0, 1'b0, 0, 3'd0);
    check("R6", trigEvent, 1'b1, "ext low qualifies");

    // R1: codes 6 and 7 behave as dont care
    wr("R1", NUM_CH, 3'd0);
    wr("R1", 1, 3'd7);
    wr("R1", 2, 3'd6);
    wr("R1", 0, 3'd1);
    step("R1", 8'h01, 1'b0, 1'b0, 1'b0, 0, 3'd0);
    step("R1", 8'h01, 1'b0, 1'b0, 1'b0, 0, 3'd0);
    check("R1", trigEvent, 1'b1, "codes 6/7 ignored");

    // R8: active low output
    wr("R8", NUM_CH + 1, 3'd1);
    step("R8", 8'h00, 1'b0, 1'b0, 1'b0, 0, 3'd0);
    step("R8", 8'h00, 1'b0, 1'b0, 1'b0, 0, 3'd0);
    check("R8", trigOut, 1'b1, "idle level high");

    // R9: writes beyond the map are ignored
    for (int a = NUM_CH + 2; a < (1 << ADDR_W); a++) wr("R9", a, 3'd0);
    step("R9", 8'h01, 1'b0, 1'b0, 1'b0, 0, 3'd0);
    step("R9", 8'h01, 1'b0, 1'b0, 1'b0, 0, 3'd0);
    check("R9", trigEvent, 1'b1, "ignored write");
    check("R9", trigOut, 1'b0, "polarity kept");

    // R3: random mix of writes, restarts and probes
    for (int i = 0; i < 600; i++) begin
      int sel = int'($urandom % 16);
      logic [2:0] d = (sel < 6) ? 3'($urandom) : 3'd0;
      step("R3", NUM_CH'($urandom) & NUM_CH'($urandom), 1'($urandom),
           ($urandom % 20) == 0, ($urandom % 4) == 0,
           int'($urandom % (1 << ADDR_W)), d);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule